// File: doc/BRIEF.md
# Two-Dimensional Adaptive FIR Filter with Multiplier-Free Distributed Arithmetic

The block filters a raster-scanned image stream through a square window of adaptive coefficients and adapts those coefficients with a delayed least-mean-square rule. Pixels enter one per accepted cycle through a single port, together with the desired response for that pixel. The block returns the filter output and the error against the desired response. The inner product uses no multipliers. Each bit slice of every group of four taps forms a 4-bit address. A small adder-and-gate network turns that address into the sum of the selected weights. The slice sums are shifted and accumulated, and the sign slice is subtracted.

The window comes from one shared delay line whose rows are one image width long. Taps that would reach across the left edge of a row read as zero. The coefficient update reads its older window from a deeper point on the same delay line, so no second copy of the window is kept. The taps are split across parallel sub-blocks. Their sums are registered and then combined in a second stage, so the longest path grows with the sub-block size and not with the window size. The pipeline advances only on accepted samples. The result for sample m appears one cycle after sample m+2 is accepted.

Top module: `da2d_lms_fir`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid`, `out_y` and `out_err` are all zero, and all weights are zero.
- R2: The result for sample m (samples counted from 0 after reset) is presented, with `out_valid` high for exactly one cycle, in the cycle after sample m+2 is accepted. No result appears after the first two samples.
- R3: `out_y` for sample m equals the two's-complement sum, over all WIN×WIN taps, of weight × window pixel, wrapped to YW bits. The weights used are those held just before sample m+1 was accepted.
- R4: Window tap (row r, column c) for sample m holds the pixel accepted r·IMG_W+c samples earlier. It reads as zero when c exceeds the column of sample m, where the column is the sample index modulo IMG_W. It also reads as zero before any such pixel exists.
- R5: `out_err` for sample m equals the desired value of sample m minus `out_y` of sample m, wrapped to YW bits.
- R6: When sample k is accepted, with k ≥ 3, every weight t changes by ((e·x_t) >>> MU_SH), truncated to WGT_W bits and added with wrap. Here e is the error of sample k−3 and x_t is tap t of the window of sample k−3. In any other cycle the weights hold.
- R7: While `in_valid` is low, `out_valid` stays low and `out_y` and `out_err` keep their values.
- R8: Pixels are signed. The top bit slice carries weight −2^(PIX_W−1), so negative pixels enter the product with the correct sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts one pixel and its desired value this cycle |
| in_pix | input | PIX_W | Signed pixel in raster order |
| in_des | input | YW | Signed desired response for this pixel |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_y | output | YW | Signed filter output |
| out_err | output | YW | Signed error, desired minus output |

## Verification
A weight update and the capture of sub-block sums for a newer window happen on the same accepted edge. The sums must be formed from the weights as they stood before that update. The bench provokes this by streaming back-to-back samples after the third one, so that every accepted edge carries both events. A reference model, kept in sample order, computes each output before it applies the update of the same step. Any error in that ordering, or in the three-sample lag of the update, shows up as a mismatch in `out_y` within a few samples. Idle gaps are inserted between bursts to confirm that neither event fires without an accepted sample.

// File: rtl/da2d_pkg.sv
`timescale 1ns/1ps
package da2d_pkg;
  // Adaptation step: product of error and pixel scaled by a power-of-two step.
  function automatic longint lms_step(input longint e, input longint x, input int unsigned sh);
    return (e * x) >>> sh;
  endfunction
endpackage

// File: rtl/da2d_window.sv
`timescale 1ns/1ps
module da2d_window #(
  parameter int PIX_W = 8,
  parameter int WIN   = 8,
  parameter int IMG_W = 16,
  parameter int LAG   = 2,
  localparam int TAPS = WIN * WIN,
  localparam int LEN  = (WIN - 1) * IMG_W + WIN + LAG,
  localparam int CW   = $clog2(IMG_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic signed [PIX_W-1:0] pix,
  output logic signed [PIX_W-1:0] win_now [TAPS],
  output logic signed [PIX_W-1:0] win_old [TAPS]
);
  logic signed [PIX_W-1:0] line_q [LEN];
  logic [CW-1:0] col_h [LAG+1];
  logic [CW-1:0] col_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) line_q[i] <= '0;
      for (int i = 0; i <= LAG; i++) col_h[i] <= '0;
      col_next <= '0;
    end else if (shift_en) begin
      line_q[0] <= pix;
      for (int i = 1; i < LEN; i++) line_q[i] <= line_q[i-1];
      col_h[0] <= col_next;
      for (int i = 1; i <= LAG; i++) col_h[i] <= col_h[i-1];
      col_next <= (int'(col_next) == IMG_W - 1) ? '0 : col_next + 1'b1;
    end
  end

  // Both windows are taps of the one shared line; the older one sits LAG deeper.
  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      assign win_now[r*WIN+c] = (int'(col_h[0]) >= c) ? line_q[r*IMG_W+c] : '0;
      assign win_old[r*WIN+c] = (int'(col_h[LAG]) >= c) ? line_q[r*IMG_W+c+LAG] : '0;
    end
  end
endmodule

// File: rtl/da2d_subblock.sv
`timescale 1ns/1ps
module da2d_subblock #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 16,
  parameter int YW    = 30,
  parameter int TAPS  = 64,
  parameter int BASE  = 0,
  parameter int NT    = 16,
  localparam int NG   = NT / 4
) (
  input  logic signed [PIX_W-1:0] x   [TAPS],
  input  logic signed [WGT_W-1:0] w   [TAPS],
  output logic signed [YW-1:0]    acc
);
  // Partial-sum generator: the weights selected by one 4-bit slice address.
  function automatic logic signed [YW-1:0] slice_sum(
    input logic [3:0] a,
    input logic signed [WGT_W-1:0] w0, w1, w2, w3);
    logic signed [YW-1:0] s;
    s = '0;
    if (a[0]) s = s + YW'(w0);
    if (a[1]) s = s + YW'(w1);
    if (a[2]) s = s + YW'(w2);
    if (a[3]) s = s + YW'(w3);
    return s;
  endfunction

  logic signed [YW-1:0] grp_sum [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int T0 = BASE + 4 * g;
    always_comb begin
      logic signed [YW-1:0] run, ps;
      run = '0;
      for (int b = 0; b < PIX_W; b++) begin
        ps = slice_sum({x[T0+3][b], x[T0+2][b], x[T0+1][b], x[T0][b]},
                       w[T0], w[T0+1], w[T0+2], w[T0+3]);
        if (b == PIX_W - 1) run = run - (ps <<< b);
        else                run = run + (ps <<< b);
      end
      grp_sum[g] = run;
    end
  end

  always_comb begin
    acc = '0;
    for (int g = 0; g < NG; g++) acc = acc + grp_sum[g];
  end
endmodule

// File: rtl/da2d_weights.sv
`timescale 1ns/1ps
module da2d_weights #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 16,
  parameter int YW    = 30,
  parameter int TAPS  = 64,
  parameter int MU_SH = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic signed [YW-1:0]    err,
  input  logic signed [PIX_W-1:0] x_old [TAPS],
  output logic signed [WGT_W-1:0] w     [TAPS]
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [63:0] step;
    assign step = da2d_pkg::lms_step(longint'(err), longint'(x_old[t]), MU_SH);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      w[t] <= '0;
      else if (upd_en) w[t] <= w[t] + step[WGT_W-1:0];
    end
  end
endmodule

// File: rtl/da2d_lms_fir.sv
`timescale 1ns/1ps
module da2d_lms_fir #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 16,
  parameter int WIN   = 8,
  parameter int IMG_W = 16,
  parameter int NSUB  = 4,
  parameter int MU_SH = 12,
  localparam int TAPS = WIN * WIN,
  localparam int YW   = PIX_W + WGT_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [PIX_W-1:0] in_pix,
  input  logic signed [YW-1:0]    in_des,
  output logic                    out_valid,
  output logic signed [YW-1:0]    out_y,
  output logic signed [YW-1:0]    out_err
);
  localparam int NT  = TAPS / NSUB;
  localparam int LAG = 2;

  logic signed [PIX_W-1:0] win_now [TAPS];
  logic signed [PIX_W-1:0] win_old [TAPS];
  logic signed [WGT_W-1:0] wgt     [TAPS];
  logic signed [YW-1:0]    sub_acc [NSUB];
  logic signed [YW-1:0]    sub_q   [NSUB];
  logic signed [YW-1:0]    des_q0, des_q1, y_sum;
  logic                    have0, have1, err_ok;
  logic                    upd_fire;
  logic [TAPS*WGT_W-1:0]   w_flat;

  da2d_window #(.PIX_W(PIX_W), .WIN(WIN), .IMG_W(IMG_W), .LAG(LAG)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .pix(in_pix),
    .win_now(win_now), .win_old(win_old));

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    da2d_subblock #(.PIX_W(PIX_W), .WGT_W(WGT_W), .YW(YW), .TAPS(TAPS),
                    .BASE(k * NT), .NT(NT)) u_sub (
      .x(win_now), .w(wgt), .acc(sub_acc[k]));
  end

  // Update fires on an accepted sample once the error register holds real data.
  assign upd_fire = in_valid & err_ok;

  da2d_weights #(.PIX_W(PIX_W), .WGT_W(WGT_W), .YW(YW), .TAPS(TAPS), .MU_SH(MU_SH)) u_wgt (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_fire), .err(out_err),
    .x_old(win_old), .w(wgt));

  for (genvar t = 0; t < TAPS; t++) begin : g_flat
    assign w_flat[t*WGT_W +: WGT_W] = wgt[t];
  end

  always_comb begin
    y_sum = '0;
    for (int k = 0; k < NSUB; k++) y_sum = y_sum + sub_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSUB; k++) sub_q[k] <= '0;
      des_q0 <= '0; des_q1 <= '0;
      have0 <= 1'b0; have1 <= 1'b0; err_ok <= 1'b0;
      out_valid <= 1'b0; out_y <= '0; out_err <= '0;
    end else begin
      out_valid <= in_valid & have1;
      if (in_valid) begin
        for (int k = 0; k < NSUB; k++) sub_q[k] <= sub_acc[k];
        des_q0  <= in_des;
        des_q1  <= des_q0;
        out_y   <= y_sum;
        out_err <= des_q1 - y_sum;
        have0   <= 1'b1;
        have1   <= have0;
        err_ok  <= have1;
      end
    end
  end
endmodule

// File: rtl/da2d_lms_fir_chk.sv
`timescale 1ns/1ps
module da2d_lms_fir_chk #(
  parameter int YW  = 30,
  parameter int WFW = 1024
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic [YW-1:0]  out_y,
  input logic [YW-1:0]  out_err,
  input logic           upd_fire,
  input logic [WFW-1:0] w_flat
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen <= '0;
    else if (in_valid && seen != 2'd3) seen <= seen + 2'd1;
  end

  p_quiet_reset_r1: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_y == '0 && out_err == '0));
  p_first_result_r2: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> seen == 2'd3);
  p_result_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid));
  p_weights_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) !upd_fire |=> $stable(w_flat));
  p_update_needs_sample_r6: assert property (@(posedge clk) disable iff (!rst_n) upd_fire |-> in_valid);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_y) && $stable(out_err)));
endmodule

bind da2d_lms_fir da2d_lms_fir_chk #(.YW(YW), .WFW(TAPS*WGT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_y(out_y), .out_err(out_err), .upd_fire(upd_fire), .w_flat(w_flat));

// File: tb/test_da2d_lms_fir.sv
`timescale 1ns/1ps
module test_da2d_lms_fir;
  localparam int PIX_W = 8, WGT_W = 16, WIN = 8, IMG_W = 16, MU_SH = 12;
  localparam int TAPS = WIN * WIN;
  localparam int YW = PIX_W + WGT_W + $clog2(TAPS);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [PIX_W-1:0] in_pix = '0;
  logic signed [YW-1:0] in_des = '0;
  logic out_valid;
  logic signed [YW-1:0] out_y, out_err;

  always #5 clk = ~clk;

  da2d_lms_fir i_da2d_lms_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_des(in_des),
    .out_valid(out_valid), .out_y(out_y), .out_err(out_err));

  int checks = 0, errors = 0, nsamp = 0;
  bit done = 0;
  int pix_h [$];
  longint des_h [1024], y_h [1024], e_h [1024];
  logic signed [WGT_W-1:0] wm [TAPS];
  longint q_y [$], q_e [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint wrap_y(input longint v);
    logic signed [YW-1:0] t;
    t = v[YW-1:0];
    return longint'(t);
  endfunction

  // Window tap per R4: pixel r*IMG_W+c samples back, zero past the row start.
  function automatic longint tap(input int m, input int t);
    int r = t / WIN, c = t % WIN;
    int idx = m - r * IMG_W - c;
    if (m < 0 || idx < 0 || (m % IMG_W) < c) return 0;
    return longint'(pix_h[idx]);
  endfunction

  // One accepted edge: output of the previous sample with current weights (R3, R5),
  // then the update with the error and window of three samples back (R6).
  task automatic model_step(input int k);
    longint acc;
    if (k >= 1) begin
      acc = 0;
      for (int t = 0; t < TAPS; t++) acc += longint'(wm[t]) * tap(k - 1, t);
      y_h[k-1] = wrap_y(acc);
      e_h[k-1] = wrap_y(des_h[k-1] - y_h[k-1]);
    end
    if (k >= 3) begin
      for (int t = 0; t < TAPS; t++) begin
        longint dl;
        dl = (e_h[k-3] * tap(k - 3, t)) >>> MU_SH;
        wm[t] = wm[t] + WGT_W'(dl);
      end
    end
    if (k >= 2) begin
      q_y.push_back(y_h[k-2]);
      q_e.push_back(e_h[k-2]);
    end
  endtask

  task automatic send(input int p, input longint d);
    @(negedge clk);
    model_step(nsamp);
    pix_h.push_back(p);
    des_h[nsamp] = d;
    nsamp++;
    in_valid = 1'b1;
    in_pix = p[PIX_W-1:0];
    in_des = d[YW-1:0];
  endtask

  task automatic idle(input int n);
    logic signed [YW-1:0] hy, he;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    hy = out_y; he = out_err;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!out_valid, "R7 out_valid during idle", longint'(out_valid), 0);
      chk(out_y == hy && out_err == he, "R7 output held during idle", longint'(out_y), longint'(hy));
    end
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q_y.size() == 0) begin
          chk(0, "R2 unexpected result", 1, 0);
        end else begin
          longint ey, ee;
          ey = q_y.pop_front();
          ee = q_e.pop_front();
          chk(longint'(out_y) == ey, "R3 R4 R8 out_y", longint'(out_y), ey);
          chk(longint'(out_err) == ee, "R5 R6 out_err", longint'(out_err), ee);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "R2 watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < TAPS; t++) wm[t] = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(out_y == '0, "R1 out_y in reset", longint'(out_y), 0);
    chk(out_err == '0, "R1 out_err in reset", longint'(out_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && out_y == '0, "R1 after reset release", longint'(out_y), 0);

    send(int'($urandom_range(0, 255)) - 128, 100);
    send(int'($urandom_range(0, 255)) - 128, -200);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R2 no result after two samples", longint'(out_valid), 0);

    // Random pixels, with short idle gaps.
    for (int i = 0; i < 220; i++) begin
      send(int'($urandom_range(0, 255)) - 128, longint'($urandom_range(0, 4000)) - 2000);
      if ($urandom_range(0, 9) == 0) idle(2);
    end
    idle(3);
    // Constant negative pixels exercise the subtracted sign slice (R8).
    for (int i = 0; i < 80; i++) send(-128, longint'($urandom_range(0, 400)) - 200);
    idle(2);
    for (int i = 0; i < 80; i++) send(-37, 500);
    idle(2);
    for (int i = 0; i < 80; i++) send(127, -300);
    idle(3);

    chk(q_y.size() == 0, "R2 all expected results seen", longint'(q_y.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule